// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a synchronous design read and write an external 16-bit asynchronous static RAM. The RAM has an active-low chip enable, an active-high chip select, an active-low output enable, an active-low write enable and one active-low enable per byte lane. On the user side the controller takes a request with a read/write flag, an address, write data and a two-bit lane mask. It answers with a one-cycle done pulse. For reads, the captured data is on `rdata_o` from that same edge.

All phase lengths are whole clock counts. They are computed at elaboration from the clock period and the speed grade. Each phase uses ceiling division, so every minimum interval of the memory is met and every maximum access time has passed before data is sampled. The controller accepts a request only while it is idle. Requests that arrive while it is busy are ignored.

The data bus is split into an output word, an input word and an output-enable. The pad ring merges them into a tri-state bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the memory is deselected: `mem_ce_n_o`=1, `mem_cs_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1 and `mem_be_n_o`=2'b11. In the same state `mem_dq_oe_o`, `busy_o` and `done_o` are all 0.
- R2: A request is taken on a rising edge where `req_i`=1 and `busy_o`=0. From the cycle after a non-empty request is taken, `busy_o` stays 1 until the access has finished. Address, data and mask are latched at acceptance. Requests seen while `busy_o`=1 are ignored.
- R3: A read holds `mem_ce_n_o`=0, `mem_cs_o`=1, `mem_oe_n_o`=0 and `mem_we_n_o`=1 for RD = ceil(max(tAA,tOE)/T) cycles. tAA is 55/70 ns and tOE is 25/35 ns for the fast/slow grade. Data is sampled on the edge that ends this phase, and `done_o` is 1 for the cycle after that edge.
- R4: Mask bit 0 selects data bits 7:0 and drives `mem_be_n_o[0]` low. Mask bit 1 selects bits 15:8 and drives `mem_be_n_o[1]` low. A lane that is not selected keeps its enable high and returns zero in `rdata_o`.
- R5: After a read, the controller deselects the memory for HZ = ceil(tHZ/T) cycles, with tHZ = 20/25 ns. During these cycles `busy_o`=1 and `mem_dq_oe_o`=0.
- R6: A write has three parts. First, one setup cycle with chip and lanes enabled and `mem_we_n_o`=1. Then WR cycles with `mem_we_n_o`=0. Then one cycle with `mem_we_n_o`=1 again. WR = max(ceil(max(tWP,tAW,tDW)/T), ceil(tRC/T)-2, 1), with tWP 40/50, tAW 45/60, tDW 25/30 and tRC 55/70 ns.
- R7: `mem_oe_n_o` stays 1 whenever `mem_we_n_o` is 0.
- R8: `mem_dq_oe_o` is 1 only during the write-enable-low cycles and the one cycle after them. During those cycles `mem_dq_o` carries the latched write data and `mem_addr_o` does not change.
- R9: A write finishes with `done_o`=1 and `busy_o`=0 in the cycle after the hold cycle, and the memory is deselected again.
- R10: A request with mask 2'b00 asserts no memory strobe. It gives `done_o`=1 in the cycle after acceptance, with `busy_o` remaining 0, and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Lane mask, bit 0 = bits 7:0 |
| busy_o | output | 1 | Access in progress, requests ignored |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | DATA_W | Read data, updated with done on reads |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_cs_o | output | 1 | Chip select, active high |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_be_n_o | output | DATA_W/8 | Lane enables, active low |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_i | input | DATA_W | Data returned from memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |

## Verification
With an 8 ns clock and the fast grade, RD=7, HZ=3 and WR=6, and the bench derives these with its own arithmetic. Counted from the accepting edge:
- Read data and done appear after edge RD, and busy drops after edge RD+HZ.
- Write done appears after edge WR+2.
- An empty-mask done appears after the accepting edge itself.

The bench steps through every cycle of each access at the falling clock edge. In each cycle it compares the full set of strobes, busy and done against the value expected at that offset. This way a phase that is one cycle early or late is reported in the cycle where it goes wrong.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // grade-dependent limits in ns (fast != 0 selects the quicker grade)
  function automatic int unsigned t_cyc(input int unsigned fast);
    return (fast != 0) ? 55 : 70;
  endfunction
  function automatic int unsigned t_oe(input int unsigned fast);
    return (fast != 0) ? 25 : 35;
  endfunction
  function automatic int unsigned t_hz(input int unsigned fast);
    return (fast != 0) ? 20 : 25;
  endfunction
  function automatic int unsigned t_wp(input int unsigned fast);
    return (fast != 0) ? 40 : 50;
  endfunction
  function automatic int unsigned t_aw(input int unsigned fast);
    return (fast != 0) ? 45 : 60;
  endfunction
  function automatic int unsigned t_dw(input int unsigned fast);
    return (fast != 0) ? 25 : 30;
  endfunction

  function automatic int unsigned rd_cycles(input int unsigned per, input int unsigned fast);
    return imax(cdiv(imax(t_cyc(fast), t_oe(fast)), per), 1);
  endfunction

  function automatic int unsigned hz_cycles(input int unsigned per, input int unsigned fast);
    return imax(cdiv(t_hz(fast), per), 1);
  endfunction

  // one setup and one hold cycle frame the pulse; the pulse covers the rest of the cycle time
  function automatic int unsigned wr_cycles(input int unsigned per, input int unsigned fast);
    int unsigned lim;
    int unsigned cyc;
    lim = cdiv(imax(imax(t_wp(fast), t_aw(fast)), t_dw(fast)), per);
    cyc = cdiv(t_cyc(fast), per);
    cyc = (cyc > 2) ? cyc - 2 : 1;
    return imax(imax(lim, cyc), 1);
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned HZ_CYC = 3,
  parameter int unsigned WR_CYC = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  input  logic   mask_any_i,
  output logic   accept_o,
  output logic   busy_o,
  output logic   sample_o,
  output logic   done_o,
  output logic   lanes_on_o,
  output logic   drive_o,
  output logic   ce_n_o,
  output logic   cs_o,
  output logic   we_n_o,
  output logic   oe_n_o
);

  localparam int unsigned MAX_CYC = imax(imax(RD_CYC, HZ_CYC), WR_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept_o = req_i && (phase_q == PH_IDLE);
  assign busy_o   = (phase_q != PH_IDLE);
  assign sample_o = (phase_q == PH_READ) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept_o) begin
            if (!mask_any_i) begin
              done_o <= 1'b1;
            end else if (we_i) begin
              phase_q <= PH_WSETUP;
            end else begin
              phase_q <= PH_READ;
              cnt_q   <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        PH_READ: begin
          if (cnt_zero) begin
            phase_q <= PH_TURN;
            cnt_q   <= CNT_W'(HZ_CYC - 1);
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_TURN: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        PH_WSETUP: begin
          phase_q <= PH_WPULSE;
          cnt_q   <= CNT_W'(WR_CYC - 1);
        end
        PH_WPULSE: begin
          if (cnt_zero) phase_q <= PH_WHOLD;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        PH_WHOLD: begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // strobes decode straight from the phase register
  always_comb begin
    ce_n_o     = 1'b1;
    cs_o       = 1'b0;
    we_n_o     = 1'b1;
    oe_n_o     = 1'b1;
    lanes_on_o = 1'b0;
    drive_o    = 1'b0;
    unique case (phase_q)
      PH_READ: begin
        ce_n_o     = 1'b0;
        cs_o       = 1'b1;
        oe_n_o     = 1'b0;
        lanes_on_o = 1'b1;
      end
      PH_WSETUP: begin
        ce_n_o     = 1'b0;
        cs_o       = 1'b1;
        lanes_on_o = 1'b1;
      end
      PH_WPULSE: begin
        ce_n_o     = 1'b0;
        cs_o       = 1'b1;
        we_n_o     = 1'b0;
        lanes_on_o = 1'b1;
        drive_o    = 1'b1;
      end
      PH_WHOLD: begin
        ce_n_o     = 1'b0;
        cs_o       = 1'b1;
        lanes_on_o = 1'b1;
        drive_o    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              sample_i,
  input  logic              lanes_on_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mask_any_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;

  assign mask_any_o  = |be_i;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = drive_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] rd_q;

    assign mem_be_n_o[l]     = ~(lanes_on_i & be_q[l]);
    assign rdata_o[l*8 +: 8] = rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rd_q <= '0;
      else if (sample_i) rd_q <= be_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned FAST_GRADE    = 1,
  localparam int unsigned LANES        = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_cs_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [LANES-1:0]  mem_be_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int unsigned RD_CYC = rd_cycles(CLK_PERIOD_NS, FAST_GRADE);
  localparam int unsigned HZ_CYC = hz_cycles(CLK_PERIOD_NS, FAST_GRADE);
  localparam int unsigned WR_CYC = wr_cycles(CLK_PERIOD_NS, FAST_GRADE);

  logic accept;
  logic sample;
  logic lanes_on;
  logic drive;
  logic mask_any;

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC),
    .HZ_CYC(HZ_CYC),
    .WR_CYC(WR_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .mask_any_i (mask_any),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .sample_o   (sample),
    .done_o     (done_o),
    .lanes_on_o (lanes_on),
    .drive_o    (drive),
    .ce_n_o     (mem_ce_n_o),
    .cs_o       (mem_cs_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .sample_i    (sample),
    .lanes_on_i  (lanes_on),
    .drive_i     (drive),
    .mem_dq_i    (mem_dq_i),
    .mask_any_o  (mask_any),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_n_o  (mem_be_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned LANES         = 2,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned FAST_GRADE    = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [LANES-1:0]  be_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_cs_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [LANES-1:0]  mem_be_n_o,
  input logic              mem_dq_oe_o
);

  localparam int unsigned WR_CYC = wr_cycles(CLK_PERIOD_NS, FAST_GRADE);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!mem_we_n_o) we_low_cnt <= we_low_cnt + 1'b1;
    else                  we_low_cnt <= '0;
  end

  p_idle_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_ce_n_o && !mem_cs_o && mem_we_n_o && mem_oe_n_o && (&mem_be_n_o)));

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && (be_i != '0)) |=> busy_o);

  p_read_selects_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_ce_n_o && mem_cs_o));

  p_we_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> $past(!mem_ce_n_o && mem_we_n_o));

  p_we_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_low_cnt == 16'(WR_CYC)));

  p_no_oe_in_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

  p_drive_only_writing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_n_o && !mem_ce_n_o && mem_cs_o));

  p_addr_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .LANES         (LANES),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .FAST_GRADE    (FAST_GRADE)
) i_sram_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .be_i        (be_i),
  .busy_o      (busy_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_cs_o    (mem_cs_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_be_n_o  (mem_be_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  localparam int AW   = 8;
  localparam int TCK  = 8;
  localparam int RD   = (55 + TCK - 1) / TCK;
  localparam int HZ   = (20 + TCK - 1) / TCK;
  localparam int WRA  = (45 + TCK - 1) / TCK;
  localparam int WRB  = RD - 2;
  localparam int WR   = (WRA > WRB) ? WRA : WRB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [1:0]    be = '0;
  logic          busy, done;
  logic [15:0]   rdata;
  logic [AW-1:0] mem_addr;
  logic          ce_n, cs, we_n, oe_n, dq_oe;
  logic [1:0]    be_n;
  logic [15:0]   dq_out;
  logic [15:0]   dq_in;

  logic [15:0]   mem    [256];
  logic [15:0]   shadow [256];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_ctrl #(
    .ADDR_W(AW), .DATA_W(16), .CLK_PERIOD_NS(TCK), .FAST_GRADE(1)
  ) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_cs_o(cs), .mem_we_n_o(we_n),
    .mem_oe_n_o(oe_n), .mem_be_n_o(be_n), .mem_dq_o(dq_out), .mem_dq_i(dq_in),
    .mem_dq_oe_o(dq_oe)
  );

  // memory model: lanes not enabled return a junk byte
  always_comb begin
    if (!ce_n && cs && !oe_n && we_n) begin
      dq_in[7:0]  = be_n[0] ? 8'hA5 : mem[mem_addr][7:0];
      dq_in[15:8] = be_n[1] ? 8'hA5 : mem[mem_addr][15:8];
    end else begin
      dq_in = 16'h5A5A;
    end
  end

  always @(posedge we_n) begin
    if (rst_n && !ce_n && cs) begin
      if (!be_n[0]) mem[mem_addr][7:0]  = dq_oe ? dq_out[7:0]  : 8'h00;
      if (!be_n[1]) mem[mem_addr][15:8] = dq_oe ? dq_out[15:8] : 8'h00;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pins();
    return {ce_n, cs, we_n, oe_n, be_n, dq_oe, busy, done};
  endfunction

  function automatic logic [8:0] idle_v(input bit b, input bit d);
    return {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, b, d};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    int n;
    logic [15:0] exp_rd;
    n = (m == 2'b00) ? 1 : (wr ? WR + 3 : RD + HZ + 1);
    exp_rd = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d; be = m;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~d; be = ~m;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (m == 2'b00) begin
        chk(pins() == idle_v(1'b0, 1'b1), "R10 empty mask", 32'(pins()), 32'(idle_v(1'b0, 1'b1)));
      end else if (!wr) begin
        if (i < RD) begin
          chk(pins() == {4'b0110, ~m, 3'b010}, "R3 read strobes", 32'(pins()), 32'({4'b0110, ~m, 3'b010}));
          if (i == 0) chk(mem_addr == a && busy, "R2 latched addr", 32'(mem_addr), 32'(a));
        end else if (i < RD + HZ) begin
          chk(pins() == idle_v(1'b1, i == RD), "R5 turnaround", 32'(pins()), 32'(idle_v(1'b1, i == RD)));
          if (i == RD) chk(rdata == exp_rd, "R4 read lanes", 32'(rdata), 32'(exp_rd));
        end else begin
          chk(pins() == idle_v(1'b0, 1'b0), "R5 back to idle", 32'(pins()), 32'(idle_v(1'b0, 1'b0)));
        end
      end else begin
        if (i == 0) begin
          chk(pins() == {4'b0111, ~m, 3'b010}, "R6 setup", 32'(pins()), 32'({4'b0111, ~m, 3'b010}));
        end else if (i <= WR) begin
          chk(pins() == {4'b0101, ~m, 3'b110}, "R6 pulse", 32'(pins()), 32'({4'b0101, ~m, 3'b110}));
          chk(oe_n == 1'b1, "R7 oe off", 32'(oe_n), 32'd1);
          chk(dq_out == d && mem_addr == a, "R8 data/addr", 32'({mem_addr, dq_out}), 32'({a, d}));
        end else if (i == WR + 1) begin
          chk(pins() == {4'b0111, ~m, 3'b110}, "R8 hold drive", 32'(pins()), 32'({4'b0111, ~m, 3'b110}));
        end else begin
          chk(pins() == idle_v(1'b0, 1'b1), "R9 write done", 32'(pins()), 32'(idle_v(1'b0, 1'b1)));
        end
      end
      if (poke && i == 1) begin
        req = 1'b1; we = ~wr; addr = a + 1'b1; wdata = 16'hFFFF; be = 2'b11;
      end
      if (poke && i == 3) req = 1'b0;
    end
    if (wr) begin
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem[k]    = 16'(k * 16'h0107 + 16'h3000);
      shadow[k] = 16'(k * 16'h0107 + 16'h3000);
    end
    #2;
    chk(pins() == idle_v(1'b0, 1'b0) && rdata == 16'h0, "R1 in reset", 32'(pins()), 32'(idle_v(1'b0, 1'b0)));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins() == idle_v(1'b0, 1'b0), "R1 after reset", 32'(pins()), 32'(idle_v(1'b0, 1'b0)));

    // full-word writes then every mask on readback
    for (int a = 0; a < 16; a++) begin
      access(1'b1, AW'(a * 5), {8'(a) ^ 8'h3C, 8'(a * 3) + 8'h51}, 2'b11, 1'b0);
    end
    for (int a = 0; a < 16; a++) begin
      for (int m = 1; m < 4; m++) access(1'b0, AW'(a * 5), 16'h0, 2'(m), 1'b0);
    end
    // single-lane writes (R4)
    for (int a = 0; a < 8; a++) begin
      access(1'b1, AW'(a * 5), 16'(16'hC0DE + a * 16'h1111), 2'(1 + (a & 1)), 1'b0);
      access(1'b0, AW'(a * 5), 16'h0, 2'b11, 1'b0);
    end
    // empty masks leave memory untouched (R10)
    access(1'b1, AW'(40), 16'hBEEF, 2'b00, 1'b0);
    access(1'b0, AW'(40), 16'h0, 2'b00, 1'b0);
    access(1'b0, AW'(40), 16'h0, 2'b11, 1'b0);
    // requests while busy are ignored (R2)
    access(1'b0, AW'(60), 16'h0, 2'b11, 1'b1);
    access(1'b1, AW'(70), 16'h1234, 2'b11, 1'b1);
    access(1'b0, AW'(61), 16'h0, 2'b11, 1'b0);
    access(1'b0, AW'(71), 16'h0, 2'b11, 1'b0);
    access(1'b0, AW'(70), 16'h0, 2'b11, 1'b0);
    // untouched neighbour still matches its initial value (R2)
    chk(mem[61] == shadow[61] && mem[71] == shadow[71], "R2 ignored request",
        32'({mem[61], mem[71]}), 32'({shadow[61], shadow[71]}));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule